// File: doc/BRIEF.md
# Pen-Event Averaging Filter

This block turns a short burst of raw touch-panel conversions into one touch report. Each conversion is a packed 32-bit word holding an X field, a Y field and a pen-level bit. The block collects up to four of these words from a valid/ready stream. A burst ends when the fourth word is accepted, or earlier when a word arrives carrying the end marker, which means the source ran out of data. One clock after the closing word is accepted, a single-cycle report strobe presents a touch flag and a 10-bit X/Y position.

The raw coordinates are inverted onto the panel's 0 to 0x3FF range, each axis on its own. The position is the truncated mean of the second and third words of the burst. The first and last words are not used for position, because they tend to be disturbed by the pen landing or lifting. A touch is declared only for a full burst whose last word shows the pen down. Every other burst produces a no-touch report. An abort input drops a partial burst without producing a report.

Stream rules: a word is taken on a cycle where `smp_valid` and `smp_ready` are both high. `smp_ready` is high except during a cycle where `flush` is high. During such a cycle no word is taken, and a source must keep its word and its marker held until the handshake completes. The report side has no back-pressure: the consumer must take `rep_valid` in the cycle it is high.

Top module: `pen_burst_filter`

## Requirements
- R1: A burst holds at most four accepted words. It closes on the fourth accepted word, or on an accepted word whose `smp_last` is 1. The next accepted word opens a new burst.
- R2: Word layout: bit 31 is the pen level (0 = pen down, 1 = pen up), bits 25:16 are raw X and bits 9:0 are raw Y. All other bits are ignored.
- R3: Each axis is converted as 0x3FF minus its raw 10-bit field, X and Y independently.
- R4: The reported position on each axis is (c1 + c2) / 2, truncated. Here c1 and c2 are the converted values of the second and third words. The sum is formed 11 bits wide, so two values of 0x3FF give 0x3FF.
- R5: `rep_touch` is 1 only when the burst held exactly four words and the fourth word has pen level 0. The pen level of the earlier words has no effect.
- R6: A burst of one, two or three words, or a four-word burst that ends pen up, produces a report with `rep_touch` = 0. In that report, `rep_x` and `rep_y` keep their previous values.
- R7: While `flush` is high, `smp_ready` is 0 and no word is taken. `flush` discards the words gathered so far, and no report is ever issued for that partial burst. The next accepted word starts a new burst.
- R8: After reset, `rep_valid`, `rep_touch`, `rep_x` and `rep_y` are 0 and `smp_ready` is 1.
- R9: `rep_x` and `rep_y` change only at a report with `rep_touch` = 1.
- R10: Exactly one report is issued per closed burst, with `rep_valid` high one cycle after the closing word is accepted. No report appears at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample word offered |
| smp_ready | output | 1 | Sample word can be taken (low while flushing) |
| smp_word | input | 32 | Packed sample: pen level, raw X, raw Y |
| smp_last | input | 1 | Source ran empty after this word |
| flush | input | 1 | Discard the partial burst |
| rep_valid | output | 1 | One-cycle report strobe |
| rep_touch | output | 1 | 1 = pen down with a valid position |
| rep_x | output | 10 | Filtered X position |
| rep_y | output | 10 | Filtered Y position |

## Verification
Some properties are checked on every cycle: the burst counter never runs past the fourth slot, a flush always empties it, and a report never appears except one cycle after an accepted word. The checks also cover the cycle following a flush, which can never carry a report. A touch report must follow a word whose pen bit was 0, and the position outputs must stay still apart from touch reports. The scenarios show what no single-cycle property can: the actual inverted and truncated averages, including the all-zero and all-ones raw extremes, and the pen-up and short-burst outcomes. They also show that a flushed partial burst really vanishes and that the burst after it is framed correctly. Finally, they show that four unmarked words close a burst on their own.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  localparam int unsigned DEF_WORD_W   = 32;
  localparam int unsigned DEF_COORD_W  = 10;
  localparam int unsigned DEF_SAMPLES  = 4;
  localparam int unsigned DEF_X_LSB    = 16;
  localparam int unsigned DEF_Y_LSB    = 0;
  localparam int unsigned DEF_PEN_BIT  = 31;
  localparam int unsigned DEF_PICK_A   = 1;
  localparam int unsigned DEF_PICK_B   = 2;
  localparam int unsigned NUM_AXES     = 2;

  typedef enum logic [0:0] {
    AXIS_X = 1'b0,
    AXIS_Y = 1'b1
  } axis_e;
endpackage

// File: rtl/pbf_gather.sv
module pbf_gather #(
  parameter int unsigned SAMPLES = pbf_pkg::DEF_SAMPLES,
  parameter int unsigned COORD_W = pbf_pkg::DEF_COORD_W,
  parameter int unsigned PICK_A  = pbf_pkg::DEF_PICK_A,
  parameter int unsigned PICK_B  = pbf_pkg::DEF_PICK_B
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       take,
  input  logic                                       mark,
  input  logic                                       flush,
  input  logic [pbf_pkg::NUM_AXES-1:0][COORD_W-1:0]  fld,
  output logic                                       close_o,
  output logic                                       full_o,
  output logic [pbf_pkg::NUM_AXES-1:0][COORD_W-1:0]  pick_a,
  output logic [pbf_pkg::NUM_AXES-1:0][COORD_W-1:0]  pick_b
);
  localparam int unsigned CNT_W    = $clog2(SAMPLES + 1);
  localparam int unsigned LAST_IDX = SAMPLES - 1;

  logic [CNT_W-1:0] slot;
  logic             at_last;

  assign at_last = (slot == CNT_W'(LAST_IDX));
  assign close_o = take && (mark || at_last);
  assign full_o  = at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (flush) begin
      slot <= '0;
    end else if (take) begin
      slot <= close_o ? '0 : slot + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pick_a <= '0;
      pick_b <= '0;
    end else if (take) begin
      if (slot == CNT_W'(PICK_A)) pick_a <= fld;
      if (slot == CNT_W'(PICK_B)) pick_b <= fld;
    end
  end

  assert_slot_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= CNT_W'(LAST_IDX));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot == '0));
endmodule

// File: rtl/pbf_axis_avg.sv
module pbf_axis_avg #(
  parameter int unsigned COORD_W = pbf_pkg::DEF_COORD_W
) (
  input  logic [COORD_W-1:0] raw_a,
  input  logic [COORD_W-1:0] raw_b,
  output logic [COORD_W-1:0] mean
);
  localparam logic [COORD_W-1:0] FULL = {COORD_W{1'b1}};

  logic [COORD_W-1:0] inv_a;
  logic [COORD_W-1:0] inv_b;
  logic [COORD_W:0]   total;

  always_comb begin
    inv_a = FULL - raw_a;
    inv_b = FULL - raw_b;
    total = {1'b0, inv_a} + {1'b0, inv_b};
    mean  = total[COORD_W:1];
  end
endmodule

// File: rtl/pen_burst_filter.sv
module pen_burst_filter #(
  parameter int unsigned WORD_W  = pbf_pkg::DEF_WORD_W,
  parameter int unsigned COORD_W = pbf_pkg::DEF_COORD_W,
  parameter int unsigned SAMPLES = pbf_pkg::DEF_SAMPLES,
  parameter int unsigned X_LSB   = pbf_pkg::DEF_X_LSB,
  parameter int unsigned Y_LSB   = pbf_pkg::DEF_Y_LSB,
  parameter int unsigned PEN_BIT = pbf_pkg::DEF_PEN_BIT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [WORD_W-1:0]  smp_word,
  input  logic               smp_last,
  input  logic               flush,
  output logic               rep_valid,
  output logic               rep_touch,
  output logic [COORD_W-1:0] rep_x,
  output logic [COORD_W-1:0] rep_y
);
  import pbf_pkg::*;

  localparam int unsigned LSB_OF [NUM_AXES] = '{X_LSB, Y_LSB};

  logic                               take;
  logic                               closing;
  logic                               full;
  logic                               pen_up;
  logic                               touch_now;
  logic                               word_unused;
  logic [NUM_AXES-1:0][COORD_W-1:0]   fld;
  logic [NUM_AXES-1:0][COORD_W-1:0]   pick_a;
  logic [NUM_AXES-1:0][COORD_W-1:0]   pick_b;
  logic [NUM_AXES-1:0][COORD_W-1:0]   mean;

  assign smp_ready   = ~flush;
  assign take        = smp_valid & smp_ready;
  assign pen_up      = smp_word[PEN_BIT];
  assign touch_now   = full & ~pen_up;
  assign word_unused = ^smp_word;

  for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
    assign fld[ax] = smp_word[LSB_OF[ax] +: COORD_W];

    pbf_axis_avg #(.COORD_W(COORD_W)) u_avg (
      .raw_a (pick_a[ax]),
      .raw_b (pick_b[ax]),
      .mean  (mean[ax])
    );
  end

  pbf_gather #(
    .SAMPLES (SAMPLES),
    .COORD_W (COORD_W),
    .PICK_A  (DEF_PICK_A),
    .PICK_B  (DEF_PICK_B)
  ) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .mark    (smp_last),
    .flush   (flush),
    .fld     (fld),
    .close_o (closing),
    .full_o  (full),
    .pick_a  (pick_a),
    .pick_b  (pick_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_valid <= 1'b0;
      rep_touch <= 1'b0;
      rep_x     <= '0;
      rep_y     <= '0;
    end else begin
      rep_valid <= closing;
      if (closing) begin
        rep_touch <= touch_now;
        if (touch_now) begin
          rep_x <= mean[AXIS_X];
          rep_y <= mean[AXIS_Y];
        end
      end
    end
  end

  assert_report_follows_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> $past(smp_valid && smp_ready));

  assert_flush_blocks_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rep_valid);

  assert_touch_pen_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_touch) |-> !$past(smp_word[PEN_BIT]));

  assert_position_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rep_valid && rep_touch) |-> ($stable(rep_x) && $stable(rep_y)));
endmodule

// File: tb/pen_burst_filter_test.sv
module pen_burst_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [31:0] smp_word = 32'h0;
  logic        smp_last = 1'b0;
  logic        flush = 1'b0;
  logic        rep_valid;
  logic        rep_touch;
  logic [9:0]  rep_x;
  logic [9:0]  rep_y;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  bit live   = 0;

  logic [20:0] expq [$];
  int mdl_x = 0, mdl_y = 0;
  int held_x = 0, held_y = 0;

  always #2 clk = ~clk;

  pen_burst_filter uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_word(smp_word), .smp_last(smp_last), .flush(flush),
    .rep_valid(rep_valid), .rep_touch(rep_touch), .rep_x(rep_x), .rep_y(rep_y)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // R2 layout: pen bit 31, X 25:16, Y 9:0, other bits filled with junk
  function automatic logic [31:0] mk(input bit pen, input int x, input int y, input bit junk);
    logic [9:0] xv = x[9:0];
    logic [9:0] yv = y[9:0];
    return {pen, {5{junk}}, xv, {6{junk}}, yv};
  endfunction

  // R3/R4 model: invert to 1023-raw, then truncated mean
  function automatic int exp_mean(input int a, input int b);
    return ((1023 - a) + (1023 - b)) / 2;
  endfunction

  task automatic put_word(input logic [31:0] w, input bit lst);
    smp_valid = 1'b1;
    smp_word  = w;
    smp_last  = lst;
    @(posedge clk); #1;
    smp_valid = 1'b0;
    smp_last  = 1'b0;
    smp_word  = 32'hA5A5_5A5A;
  endtask

  task automatic burst(input logic [31:0] s0, input logic [31:0] s1,
                       input logic [31:0] s2, input logic [31:0] s3,
                       input int n, input bit mark, input int gap);
    logic [31:0] w [4];
    bit t;
    w[0] = s0; w[1] = s1; w[2] = s2; w[3] = s3;
    t = (n == 4) && !s3[31];
    if (t) begin
      mdl_x = exp_mean(int'(s1[25:16]), int'(s2[25:16]));
      mdl_y = exp_mean(int'(s1[9:0]),   int'(s2[9:0]));
    end
    expq.push_back({t, mdl_x[9:0], mdl_y[9:0]});
    for (int i = 0; i < n; i++) begin
      put_word(w[i], mark && (i == n - 1));
      repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live) begin
      if (rep_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, "R10", "unexpected report", 1, 0);
        end else begin
          logic [20:0] e;
          e = expq.pop_front();
          check(rep_touch == e[20], e[20] ? "R5" : "R6", "touch flag", int'(rep_touch), int'(e[20]));
          check(rep_x == e[19:10], e[20] ? "R4" : "R6", "x", int'(rep_x), int'(e[19:10]));
          check(rep_y == e[9:0],   e[20] ? "R4" : "R6", "y", int'(rep_y), int'(e[9:0]));
          held_x = int'(e[19:10]);
          held_y = int'(e[9:0]);
        end
      end else begin
        check(int'(rep_x) == held_x && int'(rep_y) == held_y, "R9", "position moved between reports",
              int'(rep_x), held_x);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(rep_valid == 1'b0, "R8", "rep_valid after reset", int'(rep_valid), 0);
    check(rep_touch == 1'b0, "R8", "rep_touch after reset", int'(rep_touch), 0);
    check(rep_x == 10'd0 && rep_y == 10'd0, "R8", "position after reset", int'(rep_x), 0);
    check(smp_ready == 1'b1, "R8", "smp_ready after reset", int'(smp_ready), 1);
    live = 1;
    @(posedge clk); #1;

    // R4/R5: ordinary touch, back-to-back words
    burst(mk(0,5,7,0), mk(0,'h100,'h200,0), mk(0,'h102,'h201,0), mk(0,9,9,0), 4, 1, 0);
    repeat (3) begin @(posedge clk); #1; end
    // R4: raw zeros invert to 0x3FF, 11-bit sum must not wrap
    burst(mk(1,3,3,1), mk(0,0,0,1), mk(0,0,0,1), mk(0,1,1,1), 4, 1, 1);
    repeat (2) begin @(posedge clk); #1; end
    // R4: raw all-ones -> 0, odd sum truncates; R1 closes without marker
    burst(mk(0,1,1,0), mk(0,'h3FF,'h3FE,0), mk(0,'h3FE,'h3FB,0), mk(0,2,2,0), 4, 0, 0);
    burst(mk(0,1,1,0), mk(0,'h011,'h050,1), mk(0,'h200,'h001,0), mk(0,2,2,0), 4, 0, 2);
    repeat (3) begin @(posedge clk); #1; end
    // R5/R6: pen up on fourth word -> no touch, position held
    burst(mk(0,1,1,0), mk(0,'h055,'h066,0), mk(0,'h077,'h088,0), mk(1,2,2,0), 4, 1, 0);
    repeat (2) begin @(posedge clk); #1; end
    // R6: short bursts of 1, 2 and 3 words
    burst(mk(0,4,4,0), 32'h0, 32'h0, 32'h0, 1, 1, 0);
    burst(mk(0,4,4,0), mk(0,6,6,0), 32'h0, 32'h0, 2, 1, 1);
    burst(mk(0,4,4,0), mk(0,6,6,0), mk(0,8,8,0), 32'h0, 3, 1, 0);
    repeat (3) begin @(posedge clk); #1; end

    // R7: flush drops a partial burst
    put_word(mk(0,'h123,'h321,0), 1'b0);
    put_word(mk(0,'h0AA,'h0BB,0), 1'b0);
    flush = 1'b1; smp_valid = 1'b1; smp_last = 1'b1; smp_word = mk(0,1,1,0);
    @(negedge clk);
    check(smp_ready == 1'b0, "R7", "smp_ready during flush", int'(smp_ready), 0);
    @(posedge clk); #1;
    flush = 1'b0; smp_valid = 1'b0; smp_last = 1'b0;
    repeat (3) begin @(posedge clk); #1; end
    check(expq.size() == 0, "R7", "reports pending after flush", expq.size(), 0);
    // R7/R1: next burst framed from its own first word; R5 early pen-up ignored
    burst(mk(1,1,1,0), mk(1,'h020,'h030,0), mk(0,'h021,'h031,0), mk(0,3,3,0), 4, 1, 0);
    repeat (4) begin @(posedge clk); #1; end

    check(expq.size() == 0, "R10", "missing reports", expq.size(), 0);
    wrap_up();
  end
endmodule